// File: doc/BRIEF.md
# 100BASE-X Receive Symbol Framer

This block sits behind the code-group aligner of a 100 Mb/s receive path. Each cycle of the 25 MHz receive clock it takes one aligned 5-bit code group, which has already been descrambled and NRZI-decoded. It turns the stream into the four MII receive signals: a data nibble, data-valid, carrier-sense and receive-error. It decodes the sixteen 4B/5B data groups and recognises the idle group. It frames a packet between the two-symbol start delimiter (J, K) and the two-symbol end delimiter (T, R). It reports every decoding fault on the error output.

A mode input selects 10 Mb/s operation. In that mode the symbol stream is ignored. An external carrier-sense input then drives carrier-sense and data-valid alike, and the error output stays low. Every output is registered, so it reflects the code group that was present one clock earlier.

Top module: `mii_rx_framer`

## Requirements
- R1: After reset, and while reset is held, the outputs `rxd_o`, `rx_dv_o`, `crs_o` and `rx_er_o` are all 0.
- R2: Every output reflects the code group sampled at the previous rising clock edge, so the latency is exactly one clock.
- R3: Inside a frame, a data code group puts its nibble on `rxd_o` with `rx_dv_o`=1 and `rx_er_o`=0. The code for each nibble, from 0 to F in order, is 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: In 100 Mb/s mode, `crs_o` is 1 for every code group other than IDLE (11111), with one exception in R6. The IDLE group gives `crs_o`=0.
- R5: J (11000) followed by K (10001) starts a frame. The output cycle for J shows `crs_o`=1 and `rx_dv_o`=0. The output cycle for K shows `rx_dv_o`=1. Both cycles show `rxd_o`=0101.
- R6: Outside a frame, a group that is neither IDLE nor J is a false carrier, and so is a J that is not followed by K. A false carrier gives `rx_er_o`=1, `rxd_o`=1110 and `rx_dv_o`=0. These outputs hold on every group until IDLE returns. If the group that follows J is IDLE, `crs_o` is 0 for that cycle.
- R7: T (01101) followed by R (00111) ends a frame. `rx_dv_o` is 0 from the output cycle of T onward, `crs_o` stays 1 through the output cycle of R, and `rx_er_o` stays 0.
- R8: Inside a frame, a group that is not a data group, T or IDLE (J, K, R or any unused code) gives `rx_er_o`=1 with `rx_dv_o`=1, `crs_o`=1 and `rxd_o`=0000. The frame continues.
- R9: IDLE inside a frame with no T/R before it ends the frame, giving `rx_er_o`=1, `rx_dv_o`=0, `crs_o`=0 and `rxd_o`=0000.
- R10: A T that is not followed by R gives `rx_er_o`=1, `rx_dv_o`=0 and `rxd_o`=1110. If the group after T is not IDLE, the error is held as in R6 until IDLE returns.
- R11: While `ten_mode_i`=1, `crs_o` and `rx_dv_o` both equal `ext_crs_i` as sampled one clock earlier. `rx_er_o` and `rxd_o` are 0, and the framer is in the line-idle condition when it returns to 100 Mb/s mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz receive symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 5 | Aligned, decoded 5-bit code group |
| ten_mode_i | input | 1 | 1 selects 10 Mb/s operation |
| ext_crs_i | input | 1 | External carrier sense used in 10 Mb/s mode |
| rxd_o | output | 4 | MII receive nibble |
| rx_dv_o | output | 1 | MII receive data valid |
| crs_o | output | 1 | MII carrier sense |
| rx_er_o | output | 1 | MII receive error |

## Verification
The assertions check four relations on every cycle:
- data-valid is never high without carrier-sense;
- an IDLE group in 100 Mb/s mode always clears carrier-sense;
- data-valid can only rise right after a J then K;
- a false carrier always carries the 1110 nibble.

They also check that data-valid follows carrier-sense in 10 Mb/s mode, and that a T/R end always drops data-valid while carrier-sense is still up.

Only the bench's scenarios can show that the right nibble comes out for each data group, and that error conditions hold until IDLE returns. The same applies to the exact recovery after a broken start or end delimiter, an early IDLE or a mode switch.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  localparam int unsigned SYM_W = 5;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned NUM_DATA = 1 << NIB_W;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;

  typedef enum logic [2:0] {
    SC_DATA, SC_IDLE, SC_J, SC_K, SC_T, SC_R, SC_BAD
  } sym_cls_e;

  typedef enum logic [2:0] {
    FS_LINE_IDLE, FS_SAW_J, FS_FRAME, FS_SAW_T, FS_ERR_HOLD
  } fr_state_e;

  typedef struct packed {
    logic [NIB_W-1:0] rxd;
    logic             dv;
    logic             crs;
    logic             er;
  } mii_rx_t;

  function automatic logic [SYM_W-1:0] cg_of_nibble(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;  4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;  4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;  4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;  4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;  4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;  4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;  4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;  default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic logic cg_is_data(input logic [SYM_W-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_DATA; i++)
      if (cg_of_nibble(NIB_W'(i)) == c) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [NIB_W-1:0] cg_to_nibble(input logic [SYM_W-1:0] c);
    logic [NIB_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_DATA; i++)
      if (cg_of_nibble(NIB_W'(i)) == c) n = NIB_W'(i);
    return n;
  endfunction

  function automatic sym_cls_e cg_class(input logic [SYM_W-1:0] c);
    sym_cls_e k;
    if (cg_is_data(c))     k = SC_DATA;
    else if (c == CG_IDLE) k = SC_IDLE;
    else if (c == CG_J)    k = SC_J;
    else if (c == CG_K)    k = SC_K;
    else if (c == CG_T)    k = SC_T;
    else if (c == CG_R)    k = SC_R;
    else                   k = SC_BAD;
    return k;
  endfunction

endpackage

// File: rtl/mrf_classify.sv
module mrf_classify
  import mrf_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output sym_cls_e         cls_o,
  output logic [NIB_W-1:0] nib_o
);
  always_comb begin
    cls_o = cg_class(sym_i);
    nib_o = cg_to_nibble(sym_i);
  end
endmodule

// File: rtl/mrf_fsm.sv
module mrf_fsm
  import mrf_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'b0101,
  parameter logic [NIB_W-1:0] FC_NIB  = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sym_cls_e         cls_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             ten_mode_i,
  input  logic             ext_crs_i,
  output mii_rx_t          out_o,
  output logic             sof_evt_o,
  output logic             eof_evt_o,
  output logic             fc_evt_o
);
  fr_state_e st_q, st_d;
  mii_rx_t   nx;

  always_comb begin
    st_d = st_q;
    nx   = '0;
    sof_evt_o = 1'b0;
    eof_evt_o = 1'b0;
    fc_evt_o  = 1'b0;
    if (ten_mode_i) begin
      st_d   = FS_LINE_IDLE;
      nx.crs = ext_crs_i;
      nx.dv  = ext_crs_i;
    end else begin
      case (st_q)
        FS_LINE_IDLE: begin
          if (cls_i == SC_J) begin
            nx.crs = 1'b1; nx.rxd = PRE_NIB; st_d = FS_SAW_J;
          end else if (cls_i != SC_IDLE) begin
            nx.crs = 1'b1; nx.er = 1'b1; nx.rxd = FC_NIB;
            fc_evt_o = 1'b1; st_d = FS_ERR_HOLD;
          end
        end
        FS_SAW_J: begin
          if (cls_i == SC_K) begin
            nx.crs = 1'b1; nx.dv = 1'b1; nx.rxd = PRE_NIB;
            sof_evt_o = 1'b1; st_d = FS_FRAME;
          end else begin
            nx.er = 1'b1; nx.rxd = FC_NIB; fc_evt_o = 1'b1;
            if (cls_i == SC_IDLE) st_d = FS_LINE_IDLE;
            else begin nx.crs = 1'b1; st_d = FS_ERR_HOLD; end
          end
        end
        FS_FRAME: begin
          case (cls_i)
            SC_DATA: begin nx.crs = 1'b1; nx.dv = 1'b1; nx.rxd = nib_i; end
            SC_T:    begin nx.crs = 1'b1; st_d = FS_SAW_T; end
            SC_IDLE: begin nx.er = 1'b1; st_d = FS_LINE_IDLE; end
            default: begin nx.crs = 1'b1; nx.dv = 1'b1; nx.er = 1'b1; end
          endcase
        end
        FS_SAW_T: begin
          if (cls_i == SC_R) begin
            nx.crs = 1'b1; eof_evt_o = 1'b1; st_d = FS_LINE_IDLE;
          end else begin
            nx.er = 1'b1; nx.rxd = FC_NIB;
            if (cls_i == SC_IDLE) st_d = FS_LINE_IDLE;
            else begin nx.crs = 1'b1; st_d = FS_ERR_HOLD; end
          end
        end
        default: begin
          if (cls_i == SC_IDLE) st_d = FS_LINE_IDLE;
          else begin nx.crs = 1'b1; nx.er = 1'b1; nx.rxd = FC_NIB; end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_LINE_IDLE;
      out_o <= '0;
    end else begin
      st_q  <= st_d;
      out_o <= nx;
    end
  end
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mrf_pkg::*;
#(
  parameter logic [3:0] PRE_NIB = 4'b0101,
  parameter logic [3:0] FC_NIB  = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] sym_i,
  input  logic       ten_mode_i,
  input  logic       ext_crs_i,
  output logic [3:0] rxd_o,
  output logic       rx_dv_o,
  output logic       crs_o,
  output logic       rx_er_o
);
  sym_cls_e         cls;
  logic [NIB_W-1:0] nib;
  mii_rx_t          mii;
  logic             sof_evt, eof_evt, fc_evt;

  mrf_classify u_cls (.sym_i(sym_i), .cls_o(cls), .nib_o(nib));

  mrf_fsm #(.PRE_NIB(PRE_NIB), .FC_NIB(FC_NIB)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cls_i(cls), .nib_i(nib),
    .ten_mode_i(ten_mode_i), .ext_crs_i(ext_crs_i), .out_o(mii),
    .sof_evt_o(sof_evt), .eof_evt_o(eof_evt), .fc_evt_o(fc_evt)
  );

  assign rxd_o   = mii.rxd;
  assign rx_dv_o = mii.dv;
  assign crs_o   = mii.crs;
  assign rx_er_o = mii.er;
endmodule

// File: rtl/mii_rx_framer_chk.sv
module mii_rx_framer_chk
  import mrf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] sym_i,
  input logic       ten_mode_i,
  input logic       ext_crs_i,
  input logic [3:0] rxd_o,
  input logic       rx_dv_o,
  input logic       crs_o,
  input logic       rx_er_o,
  input logic       sof_evt,
  input logic       eof_evt,
  input logic       fc_evt
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;

  assert_dv_implies_crs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv_o |-> crs_o);

  assert_idle_clears_crs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 0) && !$past(ten_mode_i) && ($past(sym_i) == CG_IDLE) |-> !crs_o);

  assert_dv_rise_needs_jk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 3) && $rose(rx_dv_o) && !$past(ten_mode_i)
      |-> ($past(sym_i) == CG_K) && ($past(sym_i, 2) == CG_J));

  assert_false_carrier_nibble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er_o && crs_o && !rx_dv_o |-> rxd_o == 4'b1110);

  assert_eof_drops_dv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |=> !rx_dv_o && crs_o && !rx_er_o);

  assert_sof_raises_dv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> rx_dv_o && (rxd_o == 4'b0101));

  assert_fc_flags_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fc_evt |=> rx_er_o && !rx_dv_o);

  assert_ten_mirror_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen != 0) && $past(ten_mode_i)
      |-> (rx_dv_o == crs_o) && (crs_o == $past(ext_crs_i)) && !rx_er_o);
endmodule

bind mii_rx_framer mii_rx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_i(sym_i), .ten_mode_i(ten_mode_i),
  .ext_crs_i(ext_crs_i), .rxd_o(rxd_o), .rx_dv_o(rx_dv_o), .crs_o(crs_o),
  .rx_er_o(rx_er_o), .sof_evt(sof_evt), .eof_evt(eof_evt), .fc_evt(fc_evt)
);

// File: tb/sim_mii_rx_framer.sv
module sim_mii_rx_framer;
  localparam time CLK_PERIOD = 40ns;
  localparam int  WATCHDOG_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sym_i = 5'b11111;
  logic       ten_mode_i = 1'b0;
  logic       ext_crs_i = 1'b0;
  logic [3:0] rxd_o;
  logic       rx_dv_o, crs_o, rx_er_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  mii_rx_framer u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [4:0] S_IDLE = 5'b11111, S_J = 5'b11000, S_K = 5'b10001,
                         S_T = 5'b01101, S_R = 5'b00111;

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
     12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic int data_val(input logic [4:0] s);
    for (int n = 0; n < 16; n++) if (enc(n) == s) return n;
    return -1;
  endfunction

  // bench reference: 0 line idle, 1 after J, 2 in frame, 3 after T, 4 error until idle
  int         m_ph = 0;
  logic [3:0] e_rxd = 0;
  logic       e_dv = 0, e_crs = 0, e_er = 0;
  string      e_tag = "R1";

  task automatic model(input logic [4:0] s, input logic ten, input logic ext);
    int d;
    d = data_val(s);
    e_rxd = 0; e_dv = 0; e_crs = (s != S_IDLE); e_er = 0;
    if (ten) begin
      e_crs = ext; e_dv = ext; m_ph = 0; e_tag = "R11";
      return;
    end
    if (m_ph == 0) begin
      if (s == S_IDLE) e_tag = "R4";
      else if (s == S_J) begin e_rxd = 4'b0101; m_ph = 1; e_tag = "R5"; end
      else begin e_er = 1; e_rxd = 4'b1110; m_ph = 4; e_tag = "R6"; end
    end else if (m_ph == 1) begin
      if (s == S_K) begin e_dv = 1; e_rxd = 4'b0101; m_ph = 2; e_tag = "R5"; end
      else begin e_er = 1; e_rxd = 4'b1110; m_ph = (s == S_IDLE) ? 0 : 4; e_tag = "R6"; end
    end else if (m_ph == 2) begin
      if (d >= 0) begin e_dv = 1; e_rxd = d[3:0]; e_tag = "R3"; end
      else if (s == S_T) begin m_ph = 3; e_tag = "R7"; end
      else if (s == S_IDLE) begin e_er = 1; m_ph = 0; e_tag = "R9"; end
      else begin e_dv = 1; e_er = 1; e_tag = "R8"; end
    end else if (m_ph == 3) begin
      if (s == S_R) begin m_ph = 0; e_tag = "R7"; end
      else begin e_er = 1; e_rxd = 4'b1110; m_ph = (s == S_IDLE) ? 0 : 4; e_tag = "R10"; end
    end else begin
      if (s == S_IDLE) begin m_ph = 0; e_tag = "R6"; end
      else begin e_er = 1; e_rxd = 4'b1110; e_tag = "R6"; end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({rxd_o, rx_dv_o, crs_o, rx_er_o} !== {e_rxd, e_dv, e_crs, e_er}) begin
      fails++;
      $display("FAIL %s (R2 timing): rxd/dv/crs/er actual %b/%b/%b/%b expected %b/%b/%b/%b",
               tag, rxd_o, rx_dv_o, crs_o, rx_er_o, e_rxd, e_dv, e_crs, e_er);
    end
  endtask

  // at a falling edge: check the result of the last group, then present the next
  task automatic step(input logic [4:0] s, input logic ten = 1'b0, input logic ext = 1'b0);
    @(negedge clk);
    compare(e_tag);
    sym_i = s; ten_mode_i = ten; ext_crs_i = ext;
    model(s, ten, ext);
  endtask

  task automatic frame(input int n);
    step(S_J); step(S_K);
    for (int i = 0; i < n; i++) step(enc($urandom_range(0, 15)));
    step(S_T); step(S_R); step(S_IDLE);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if ({rxd_o, rx_dv_o, crs_o, rx_er_o} !== 7'd0) begin
        fails++;
        $display("FAIL R1: outputs actual %b expected 0", {rxd_o, rx_dv_o, crs_o, rx_er_o});
      end
    end
    rst_n = 1'b1;
    step(S_IDLE); step(S_IDLE);
    // R3 R5 R7: every data nibble in one frame
    step(S_J); step(S_K);
    for (int n = 0; n < 16; n++) step(enc(n));
    step(S_T); step(S_R); step(S_IDLE); step(S_IDLE);
    // R6: junk outside a frame, then J without K
    step(enc(3)); step(5'b00000); step(S_IDLE);
    step(S_J); step(enc(1)); step(enc(2)); step(S_IDLE);
    step(S_J); step(S_IDLE); step(S_IDLE);
    // R8: invalid group and stray J, K, R inside a frame
    step(S_J); step(S_K); step(enc(5)); step(5'b00100); step(S_J); step(S_K); step(S_R);
    step(enc(9)); step(S_T); step(S_R); step(S_IDLE);
    // R9: IDLE in the middle of a frame
    step(S_J); step(S_K); step(enc(7)); step(S_IDLE); step(S_IDLE);
    // R10: T followed by something other than R, and T followed by IDLE
    step(S_J); step(S_K); step(enc(4)); step(S_T); step(enc(6)); step(enc(6)); step(S_IDLE);
    step(S_J); step(S_K); step(S_T); step(S_IDLE); step(S_IDLE);
    // R11: 10 Mb/s mode with a mid-frame switch
    step(S_J); step(S_K); step(enc(2));
    step(S_J, 1'b1, 1'b1); step(S_K, 1'b1, 1'b1); step(enc(0), 1'b1, 1'b0);
    step(S_IDLE, 1'b1, 1'b1); step(S_IDLE, 1'b1, 1'b0);
    step(enc(8)); step(S_IDLE);
    // random mix
    for (int it = 0; it < 400; it++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2, 3: frame($urandom_range(0, 12));
        4: begin step(S_J); step(S_K); step(enc(1)); step($urandom_range(0, 31)); step(S_T); step(S_R); step(S_IDLE); end
        5: begin step(S_J); step(S_K); step(enc(2)); step(S_T); step($urandom_range(0, 31)); step(S_IDLE); end
        6: begin step(S_J); step($urandom_range(0, 31)); step(S_IDLE); end
        7: for (int i = 0; i < 6; i++) step($urandom_range(0, 31));
        8: for (int i = 0; i < 5; i++) step($urandom_range(0, 31), 1'b1, 1'($urandom_range(0, 1)));
        default: step(S_IDLE);
      endcase
      step(S_IDLE);
    end
    step(S_IDLE);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule